// File: doc/BRIEF.md
# Processor Bus Transaction Sequencer

This block takes memory requests from a processor's load/store and cache-control logic and turns each one into a transaction on a 64-bit system bus. It decides the transaction class from the request's attributes. Uncached, caching-disabled and write-through store accesses become single-beat transfers of one to eight bytes. Other cacheable accesses (block fills and write-backs) become four-beat bursts that move a whole 32-byte block. Invalidation requests become address-only cycles with no data phase.

Two pending slots hold at most one read-class request (reads and invalidations) and one write request. Transactions are issued one at a time in arrival order. An external write-priority input lets the pending write reach the bus ahead of a pending read. Each transaction asks for the bus and waits for a grant. It then marks its address phase with a one-cycle start pulse, and then steps through its data beats, one per acknowledge.

Top module: `bus_txn_seq`

## Requirements
- R1: A request with `req_inhibit`, `req_cache_off`, or (`req_write` and `req_wt`) set, and `req_addr_only` clear, becomes one data beat. At the start pulse `attr_burst`=0, `attr_addr_only`=0, `attr_size` equals `req_size`, and `beat_dw` equals address bits [4:3].
- R2: A memory request that has none of the single-beat conditions becomes a burst: `attr_burst`=1, `attr_size`=32, exactly four data beats.
- R3: Burst beats present `beat_dw` starting at request address bits [4:3` ] and rising by one per beat, modulo 4.
- R4: A request with `req_addr_only`=1 produces a start pulse with `attr_addr_only`=1 and `attr_size`=0. No data beat follows, and `txn_done` pulses in the cycle after the start pulse.
- R5: At the start pulse, `attr_wt` equals the request's `req_wt`, `attr_ci` equals `req_inhibit` OR `req_cache_off`, `attr_write` equals `req_write`, and `addr_out` equals `req_addr`.
- R6: A single-beat request whose `req_size` is 0, or whose low three address bits plus `req_size` exceed 8, raises `req_err` for one cycle after it is presented and is never issued. An offset plus size of exactly 8 is legal.
- R7: `bus_req` stays high from the cycle after a request is taken until `bus_gnt` is sampled high. `ts_pulse` is high for exactly the one cycle that follows.
- R8: Each data beat holds while `beat_ack` is low and advances on an edge where it is high. `txn_done` pulses for one cycle after the last acknowledged beat.
- R9: With `wr_first` low, queued requests are issued in the order they were accepted.
- R10: With `wr_first` high when the next transaction is chosen, a pending write is issued before a pending read that arrived earlier.
- R11: `req_ready` is low exactly when the slot for the presented class is occupied. The write slot serves `req_write`=1 with `req_addr_only`=0; the read slot serves everything else.
- R12: After reset, `bus_req`, `ts_pulse`, `beat_valid`, `txn_done` and `req_err` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request presented |
| req_write | input | 1 | Request is a write |
| req_addr_only | input | 1 | Request is an invalidation with no data |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Byte count for single-beat requests |
| req_inhibit | input | 1 | Cache-inhibited page |
| req_cache_off | input | 1 | Caching globally disabled |
| req_wt | input | 1 | Write-through page |
| req_ready | output | 1 | Slot for the presented class is free |
| req_err | output | 1 | Previous request rejected for an illegal span |
| wr_first | input | 1 | Give a pending write precedence over reads |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| ts_pulse | output | 1 | Transaction start, one cycle |
| addr_out | output | ADDR_W | Transaction address |
| attr_size | output | 6 | Transfer byte count (0, 1..8 or 32) |
| attr_burst | output | 1 | Burst flag |
| attr_wt | output | 1 | Write-through flag |
| attr_ci | output | 1 | Cache-inhibited flag |
| attr_write | output | 1 | Write flag |
| attr_addr_only | output | 1 | Address-only flag |
| beat_valid | output | 1 | Data beat in progress |
| beat_dw | output | 2 | Doubleword index of the current beat |
| beat_ack | input | 1 | Beat acknowledge |
| txn_done | output | 1 | Transaction finished, one cycle |

## Verification
Classification is driven with each single-beat trigger on its own (inhibited, caching disabled, write-through store), with cacheable reads and writes, and with a write-through read. This separates a wrong single-beat condition from a wrong attribute copy. Bursts start at two different doublewords, so both the wrap and the starting index are seen. Spans are tried one byte past the boundary, exactly on it, and with size zero. Ordering runs a read followed by a write with the priority input low and then high, plus a write followed by a read, so that arrival order and forced write priority give different results.

// File: rtl/bus_txn_pkg.sv
package bus_txn_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_ADDR,
        ST_DATA
    } seq_state_e;

    typedef enum logic [1:0] {
        TC_SINGLE,
        TC_BURST,
        TC_ADDR_ONLY
    } txn_class_e;
endpackage

// File: rtl/txn_classify.sv
module txn_classify
    import bus_txn_pkg::*;
#(
    parameter int BUS_BYTES = 8,
    parameter int BEATS     = 4,
    localparam int OFF_W    = $clog2(BUS_BYTES),
    localparam int RS_W     = $clog2(BUS_BYTES) + 1,
    localparam int SZ_W     = $clog2(BUS_BYTES * BEATS) + 1
) (
    input  logic             addr_only,
    input  logic             write,
    input  logic             inhibit,
    input  logic             cache_off,
    input  logic             wt,
    input  logic [OFF_W-1:0] addr_off,
    input  logic [RS_W-1:0]  size,
    output txn_class_e       cls,
    output logic [SZ_W-1:0]  tot_size,
    output logic             err
);
    localparam int SPAN_W      = RS_W + 1;
    localparam int BLOCK_BYTES = BUS_BYTES * BEATS;

    logic              single;
    logic [SPAN_W-1:0] span;

    always_comb begin
        single   = inhibit | cache_off | (write & wt);
        span     = SPAN_W'(addr_off) + SPAN_W'(size);
        cls      = TC_BURST;
        tot_size = SZ_W'(BLOCK_BYTES);
        err      = 1'b0;
        if (addr_only) begin
            cls      = TC_ADDR_ONLY;
            tot_size = '0;
        end else if (single) begin
            cls      = TC_SINGLE;
            tot_size = SZ_W'(size);
            err      = (size == '0) || (span > SPAN_W'(BUS_BYTES));
        end
    end
endmodule

// File: rtl/txn_slots.sv
module txn_slots #(
    parameter int ENT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             push_wr,
    input  logic [ENT_W-1:0] push_ent,
    input  logic             pop,
    input  logic             wr_first,
    output logic             rd_full,
    output logic             wr_full,
    output logic             any_pending,
    output logic             sel_wr,
    output logic [ENT_W-1:0] sel_ent
);
    localparam int NSLOT = 2;

    typedef struct packed {
        logic [NSLOT-1:0]            vld;
        logic [NSLOT-1:0][ENT_W-1:0] ent;
        logic                        older_wr;
    } slot_state_t;

    slot_state_t s_d, s_q;
    logic        other_left;

    always_comb begin
        s_d         = s_q;
        rd_full     = s_q.vld[0];
        wr_full     = s_q.vld[1];
        any_pending = |s_q.vld;
        sel_wr      = s_q.vld[1] & (~s_q.vld[0] | wr_first | s_q.older_wr);
        sel_ent     = s_q.ent[sel_wr];
        other_left  = 1'b0;

        if (pop) begin
            s_d.vld[sel_wr] = 1'b0;
            s_d.older_wr    = ~sel_wr;
        end
        if (push) begin
            s_d.vld[push_wr] = 1'b1;
            s_d.ent[push_wr] = push_ent;
            other_left       = s_d.vld[~push_wr];
            if (!other_left) begin
                s_d.older_wr = push_wr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/bus_txn_seq.sv
module bus_txn_seq
    import bus_txn_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BUS_BYTES = 8,
    parameter int BEATS     = 4,
    localparam int OFF_W    = $clog2(BUS_BYTES),
    localparam int DW_W     = $clog2(BEATS),
    localparam int RS_W     = $clog2(BUS_BYTES) + 1,
    localparam int SZ_W     = $clog2(BUS_BYTES * BEATS) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_addr_only,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [RS_W-1:0]   req_size,
    input  logic              req_inhibit,
    input  logic              req_cache_off,
    input  logic              req_wt,
    output logic              req_ready,
    output logic              req_err,
    input  logic              wr_first,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              ts_pulse,
    output logic [ADDR_W-1:0] addr_out,
    output logic [SZ_W-1:0]   attr_size,
    output logic              attr_burst,
    output logic              attr_wt,
    output logic              attr_ci,
    output logic              attr_write,
    output logic              attr_addr_only,
    output logic              beat_valid,
    output logic [DW_W-1:0]   beat_dw,
    input  logic              beat_ack,
    output logic              txn_done
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [SZ_W-1:0]   size;
        txn_class_e        cls;
        logic              write;
        logic              wt;
        logic              ci;
    } txn_ent_t;

    localparam int ENT_W = $bits(txn_ent_t);

    typedef struct packed {
        seq_state_e      st;
        txn_ent_t        cur;
        logic [DW_W-1:0] cnt;
        logic            done;
        logic            err;
    } seq_state_t;

    seq_state_t   q_d, q_q;
    txn_class_e   new_cls;
    logic [SZ_W-1:0] new_size;
    logic         new_err;
    logic         wr_class;
    logic         rd_full, wr_full, any_pending, sel_wr;
    logic         push, pop;
    txn_ent_t     push_ent;
    logic [ENT_W-1:0] sel_raw;
    txn_ent_t     sel_ent;

    txn_classify #(
        .BUS_BYTES (BUS_BYTES),
        .BEATS     (BEATS)
    ) u_classify (
        .addr_only (req_addr_only),
        .write     (req_write),
        .inhibit   (req_inhibit),
        .cache_off (req_cache_off),
        .wt        (req_wt),
        .addr_off  (req_addr[OFF_W-1:0]),
        .size      (req_size),
        .cls       (new_cls),
        .tot_size  (new_size),
        .err       (new_err)
    );

    txn_slots #(
        .ENT_W (ENT_W)
    ) u_slots (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_wr     (wr_class),
        .push_ent    (push_ent),
        .pop         (pop),
        .wr_first    (wr_first),
        .rd_full     (rd_full),
        .wr_full     (wr_full),
        .any_pending (any_pending),
        .sel_wr      (sel_wr),
        .sel_ent     (sel_raw)
    );

    always_comb begin
        wr_class       = req_write & ~req_addr_only;
        req_ready      = wr_class ? ~wr_full : ~rd_full;
        push           = req_valid & req_ready & ~new_err;
        push_ent.addr  = req_addr;
        push_ent.size  = new_size;
        push_ent.cls   = new_cls;
        push_ent.write = req_write;
        push_ent.wt    = req_wt;
        push_ent.ci    = req_inhibit | req_cache_off;
        sel_ent        = txn_ent_t'(sel_raw);

        q_d      = q_q;
        q_d.done = 1'b0;
        q_d.err  = req_valid & new_err;
        pop      = 1'b0;

        unique case (q_q.st)
            ST_IDLE: begin
                if (any_pending) begin
                    pop     = 1'b1;
                    q_d.cur = sel_ent;
                    q_d.cnt = '0;
                    q_d.st  = ST_REQ;
                end
            end
            ST_REQ: begin
                if (bus_gnt) begin
                    q_d.st = ST_ADDR;
                end
            end
            ST_ADDR: begin
                if (q_q.cur.cls == TC_ADDR_ONLY) begin
                    q_d.st   = ST_IDLE;
                    q_d.done = 1'b1;
                end else begin
                    q_d.st = ST_DATA;
                end
            end
            ST_DATA: begin
                if (beat_ack) begin
                    if (q_q.cur.cls == TC_SINGLE || q_q.cnt == DW_W'(BEATS - 1)) begin
                        q_d.st   = ST_IDLE;
                        q_d.done = 1'b1;
                    end else begin
                        q_d.cnt = q_q.cnt + 1'b1;
                    end
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    assign bus_req        = (q_q.st == ST_REQ);
    assign ts_pulse       = (q_q.st == ST_ADDR);
    assign beat_valid     = (q_q.st == ST_DATA);
    assign beat_dw        = q_q.cur.addr[OFF_W +: DW_W] + q_q.cnt;
    assign addr_out       = q_q.cur.addr;
    assign attr_size      = q_q.cur.size;
    assign attr_burst     = (q_q.cur.cls == TC_BURST);
    assign attr_addr_only = (q_q.cur.cls == TC_ADDR_ONLY);
    assign attr_wt        = q_q.cur.wt;
    assign attr_ci        = q_q.cur.ci;
    assign attr_write     = q_q.cur.write;
    assign txn_done       = q_q.done;
    assign req_err        = q_q.err;
endmodule

// File: rtl/bus_txn_seq_chk.sv
module bus_txn_seq_chk #(
    parameter int BUS_BYTES = 8,
    parameter int BEATS     = 4,
    localparam int DW_W     = $clog2(BEATS),
    localparam int SZ_W     = $clog2(BUS_BYTES * BEATS) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_req,
    input logic            ts_pulse,
    input logic            beat_valid,
    input logic            beat_ack,
    input logic [DW_W-1:0] beat_dw,
    input logic            attr_burst,
    input logic            attr_addr_only,
    input logic [SZ_W-1:0] attr_size,
    input logic            txn_done
);
    AST_TS_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_pulse |=> !ts_pulse); // R7

    AST_PHASES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && ts_pulse) && !(ts_pulse && beat_valid) && !(bus_req && beat_valid)); // R7

    AST_BEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && !beat_ack |=> beat_valid && $stable(beat_dw)); // R8

    AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && beat_ack && attr_burst |=>
            !beat_valid || beat_dw == DW_W'($past(beat_dw) + 1'b1)); // R3

    AST_ADDR_ONLY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        attr_addr_only |-> !beat_valid); // R4

    AST_BURST_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_pulse && attr_burst |-> attr_size == SZ_W'(BUS_BYTES * BEATS)); // R2

    AST_SINGLE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        ts_pulse && !attr_burst && !attr_addr_only |->
            attr_size != '0 && attr_size <= SZ_W'(BUS_BYTES)); // R1

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        txn_done |-> !beat_valid && !ts_pulse); // R8
endmodule

bind bus_txn_seq bus_txn_seq_chk #(
    .BUS_BYTES (BUS_BYTES),
    .BEATS     (BEATS)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_req        (bus_req),
    .ts_pulse       (ts_pulse),
    .beat_valid     (beat_valid),
    .beat_ack       (beat_ack),
    .beat_dw        (beat_dw),
    .attr_burst     (attr_burst),
    .attr_addr_only (attr_addr_only),
    .attr_size      (attr_size),
    .txn_done       (txn_done)
);

// File: tb/bus_txn_seq_tb.sv
module bus_txn_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_addr_only = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_size = '0;
    logic        req_inhibit = 1'b0, req_cache_off = 1'b0, req_wt = 1'b0;
    logic        req_ready, req_err;
    logic        wr_first = 1'b0;
    logic        bus_req, bus_gnt = 1'b0, ts_pulse;
    logic [31:0] addr_out;
    logic [5:0]  attr_size;
    logic        attr_burst, attr_wt, attr_ci, attr_write, attr_addr_only;
    logic        beat_valid, beat_ack = 1'b0, txn_done;
    logic [1:0]  beat_dw;

    int n_checks = 0;
    int n_fail   = 0;

    always #4 clk = ~clk;

    bus_txn_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr_only(req_addr_only), .req_addr(req_addr), .req_size(req_size),
        .req_inhibit(req_inhibit), .req_cache_off(req_cache_off), .req_wt(req_wt),
        .req_ready(req_ready), .req_err(req_err), .wr_first(wr_first),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .ts_pulse(ts_pulse), .addr_out(addr_out),
        .attr_size(attr_size), .attr_burst(attr_burst), .attr_wt(attr_wt),
        .attr_ci(attr_ci), .attr_write(attr_write), .attr_addr_only(attr_addr_only),
        .beat_valid(beat_valid), .beat_dw(beat_dw), .beat_ack(beat_ack), .txn_done(txn_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic wr, input logic ao, input logic [31:0] a, input logic [3:0] sz,
                        input logic inh, input logic off, input logic w_t);
        @(negedge clk);
        req_write = wr; req_addr_only = ao; req_addr = a; req_size = sz;
        req_inhibit = inh; req_cache_off = off; req_wt = w_t; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic run_txn(input logic wr, input logic ao, input logic burst, input logic [31:0] a,
                           input logic [5:0] sz, input logic w_t, input logic ci, input string tag);
        for (int k = 0; k < 20 && !bus_req; k++) @(negedge clk);
        chk(bus_req === 1'b1, {tag, " R7 bus_req"}, bus_req, 1);
        chk(ts_pulse === 1'b0, {tag, " R7 no start before grant"}, ts_pulse, 0);
        bus_gnt = 1'b1;
        @(negedge clk);
        bus_gnt = 1'b0;
        chk(ts_pulse === 1'b1, {tag, " R7 start pulse"}, ts_pulse, 1);
        chk(addr_out === a, {tag, " R5 addr"}, addr_out, a);
        chk(attr_write === wr, {tag, " R5 write"}, attr_write, wr);
        chk(attr_wt === w_t && attr_ci === ci, {tag, " R5 wt/ci"}, {attr_wt, attr_ci}, {w_t, ci});
        chk(attr_burst === burst && attr_addr_only === ao, {tag, " R1 R2 R4 class"},
            {attr_burst, attr_addr_only}, {burst, ao});
        chk(attr_size === sz, {tag, " R1 R2 R4 size"}, attr_size, sz);
        if (ao) begin
            @(negedge clk);
            chk(beat_valid === 1'b0 && txn_done === 1'b1, {tag, " R4 no data, done"},
                {beat_valid, txn_done}, 2'b01);
        end else begin
            @(negedge clk);
            for (int i = 0; i < (burst ? 4 : 1); i++) begin
                logic [1:0] exp_dw;
                exp_dw = a[4:3] + 2'(i);
                chk(beat_valid === 1'b1 && beat_dw === exp_dw, {tag, " R3 beat dw"}, beat_dw, exp_dw);
                if (i == 0) begin
                    @(negedge clk);
                    chk(beat_valid === 1'b1 && beat_dw === exp_dw, {tag, " R8 stall holds"},
                        beat_dw, exp_dw);
                end
                beat_ack = 1'b1;
                @(negedge clk);
                beat_ack = 1'b0;
            end
            chk(beat_valid === 1'b0 && txn_done === 1'b1, {tag, " R8 done after last beat"},
                {beat_valid, txn_done}, 2'b01);
        end
        @(negedge clk);
        chk(txn_done === 1'b0, {tag, " R8 done one cycle"}, txn_done, 0);
    endtask

    task automatic t_reset();
        chk(bus_req === 0 && ts_pulse === 0 && beat_valid === 0, "R12 idle outputs",
            {bus_req, ts_pulse, beat_valid}, 0);
        chk(txn_done === 0 && req_err === 0 && req_ready === 1, "R12 done/err/ready",
            {txn_done, req_err, req_ready}, 3'b001);
    endtask

    task automatic t_single();
        send(0, 0, 32'h1003, 4'd4, 1, 0, 0);
        run_txn(0, 0, 0, 32'h1003, 6'd4, 0, 1, "R1 inhibited read");
        send(1, 0, 32'h2010, 4'd8, 0, 0, 1);
        run_txn(1, 0, 0, 32'h2010, 6'd8, 1, 0, "R1 wt store");
        send(0, 0, 32'h3007, 4'd1, 0, 1, 0);
        run_txn(0, 0, 0, 32'h3007, 6'd1, 0, 1, "R1 cache off read");
    endtask

    task automatic t_burst();
        send(0, 0, 32'h4018, 4'd8, 0, 0, 0);
        run_txn(0, 0, 1, 32'h4018, 6'd32, 0, 0, "R2 fill from dw3");
        send(1, 0, 32'h5008, 4'd8, 0, 0, 0);
        run_txn(1, 0, 1, 32'h5008, 6'd32, 0, 0, "R2 writeback from dw1");
        send(0, 0, 32'h5810, 4'd2, 0, 0, 1);
        run_txn(0, 0, 1, 32'h5810, 6'd32, 1, 0, "R5 wt read bursts");
    endtask

    task automatic t_addr_only();
        send(0, 1, 32'h6000, 4'd0, 0, 0, 0);
        run_txn(0, 1, 0, 32'h6000, 6'd0, 0, 0, "R4 invalidate");
    endtask

    task automatic t_errors();
        logic seen;
        send(0, 0, 32'h7005, 4'd4, 1, 0, 0);
        chk(req_err === 1'b1, "R6 cross boundary err", req_err, 1);
        @(negedge clk);
        chk(req_err === 1'b0, "R6 err one cycle", req_err, 0);
        send(1, 0, 32'h7000, 4'd0, 1, 0, 0);
        chk(req_err === 1'b1, "R6 zero size err", req_err, 1);
        seen = 1'b0;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            if (bus_req) seen = 1'b1;
        end
        chk(seen === 1'b0, "R6 rejected not issued", seen, 0);
        send(0, 0, 32'h7004, 4'd4, 1, 0, 0);
        chk(req_err === 1'b0, "R6 exact fit legal", req_err, 0);
        run_txn(0, 0, 0, 32'h7004, 6'd4, 0, 1, "R6 exact fit");
    endtask

    task automatic t_order(input logic prio);
        wr_first = prio;
        send(0, 1, 32'hA000, 4'd0, 0, 0, 0);
        send(0, 0, 32'h8000, 4'd8, 1, 0, 0);
        req_write = 1'b0; req_addr_only = 1'b0;
        #1;
        chk(req_ready === 1'b0, "R11 read slot full", req_ready, 0);
        req_write = 1'b1;
        #1;
        chk(req_ready === 1'b1, "R11 write slot free", req_ready, 1);
        send(1, 0, 32'h9000, 4'd8, 0, 0, 1);
        run_txn(0, 1, 0, 32'hA000, 6'd0, 0, 0, "R9 head");
        if (!prio) begin
            run_txn(0, 0, 0, 32'h8000, 6'd8, 0, 1, "R9 older read first");
            run_txn(1, 0, 0, 32'h9000, 6'd8, 1, 0, "R9 write second");
        end else begin
            run_txn(1, 0, 0, 32'h9000, 6'd8, 1, 0, "R10 write forced first");
            run_txn(0, 0, 0, 32'h8000, 6'd8, 0, 1, "R10 read after");
        end
        wr_first = 1'b0;
    endtask

    task automatic t_order_wr_then_rd();
        send(0, 1, 32'hB000, 4'd0, 0, 0, 0);
        send(1, 0, 32'hB100, 4'd4, 1, 0, 0);
        send(0, 0, 32'hB200, 4'd4, 1, 0, 0);
        run_txn(0, 1, 0, 32'hB000, 6'd0, 0, 0, "R9 head2");
        run_txn(1, 0, 0, 32'hB100, 6'd4, 0, 1, "R9 older write first");
        run_txn(0, 0, 0, 32'hB200, 6'd4, 0, 1, "R9 read second");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_burst();
        t_addr_only();
        t_errors();
        t_order(1'b0);
        t_order(1'b1);
        t_order_wr_then_rd();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule